// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the slave side of a two-wire serial memory. It decodes bus conditions from the clock and data lines and holds 2048 bytes as eight 256-byte blocks. The bus side is a clock input, a data input and a single pull-low enable for the open-drain data pad. A master addresses the block with a control byte. In a write-direction transfer, the master then sends a word address and any number of data bytes. In a read-direction transfer, the block returns bytes that start at its internal address pointer.

A single pointer is shared by all transfers and persists across them. A read with no preceding address therefore continues from the last byte accessed. A random read is a write-direction transfer that carries only the word address, followed by a repeated START and a read control byte. In a read, the master continues with ACK and ends with NACK.

The two bus inputs pass through a two-flop synchroniser. All bus edges are detected on the synchronised copies in the system clock domain. The block has no stream interface at its edge: the bus lines are plain pins, and the bus itself paces every byte.

Top module: `i2c_mem_slave`

## Requirements
- R1: The control byte is, from MSB to LSB, a 4-bit device field (value 4'b1010), three block bits and the direction bit (1 = read, 0 = write). A matching byte is acknowledged by pulling SDA low on the 9th clock. If the device field differs, no acknowledge is given, and every clock is ignored until the next START, with the pointer unchanged.
- R2: In a write-direction transfer, the byte after the control byte is a word address and is acknowledged. It loads the pointer with {block bits, word address}, which is an 11-bit address.
- R3: Each further complete byte in a write-direction transfer is stored at the pointer and acknowledged, and the pointer then advances by one.
- R4: A repeated START in the middle of a write data byte discards that byte. The pointer keeps the address that was loaded, so a following read returns the old contents at that address.
- R5: A read control byte is acknowledged, and the block then returns the byte at the pointer and advances the pointer. The block bits of a read control byte have no effect, so a read after any access to address n returns address n+1.
- R6: Data bits leave MSB first. The block starts to pull SDA low only while SCL is low.
- R7: A master ACK after a data byte makes the block send the next byte. After a master NACK, the block releases SDA and drives nothing more until a START or STOP.
- R8: The pointer wraps from 2047 to 0, both in reads and in writes.
- R9: A START at any point clears the bit count, and the block then expects a control byte. A STOP at any point releases SDA and returns the block to idle, and the pointer keeps its value.
- R10: After reset, SDA is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data pad low; 0 releases it |

## Verification
Assertions check four things on every cycle. The pad is never newly pulled low while the synchronised clock is high. The block never drives while idle. A START or STOP always leaves the expected state with the data line released. Every stored byte advances the pointer by exactly one. The bench scenarios cover what only whole transfers can show: byte values returned MSB first, the pointer carrying across separate transfers and wrapping at the top of memory, a discarded partial byte after a repeated START, and silence after a NACK or after a foreign device field.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CACK,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } bus_state_e;

endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges only count as bus conditions while the clock stays high
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cm_store.sv
module i2cm_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2cm_pkg::*;
#(
  parameter int BLK_W       = 3,
  parameter int WORD_W      = 8,
  parameter int DEV_ID      = 'hA,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe
);

  localparam int BYTE_W = 8;
  localparam int DEV_W  = BYTE_W - 1 - BLK_W;
  localparam int AW     = BLK_W + WORD_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  bus_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [BLK_W-1:0]  blk_q;
  logic [AW-1:0]     ptr;
  logic              rd_dir;
  logic              m_ack;
  logic              mem_we;
  logic [BYTE_W-1:0] mem_rd;
  logic              dev_ok;
  logic              bus_ev;

  assign bus_ev = start_det | stop_det;
  assign dev_ok = (rx_sh[BYTE_W-1 -: DEV_W] == DEV_W'(DEV_ID));
  assign mem_we = (state == ST_WDAT) && scl_fall && (bit_cnt == FULL) && !bus_ev;

  i2cm_store #(.AW(AW), .DW(BYTE_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (ptr),
    .wdata (rx_sh),
    .raddr (ptr),
    .rdata (mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      blk_q   <= '0;
      ptr     <= '0;
      rd_dir  <= 1'b0;
      m_ack   <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state   <= ST_CTRL;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        ST_CTRL, ST_ADDR, ST_WDAT: begin
          if (scl_rise && bit_cnt != FULL) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == FULL) begin
            bit_cnt <= '0;
            if (state == ST_CTRL) begin
              if (dev_ok) begin
                blk_q  <= rx_sh[BLK_W:1];
                rd_dir <= rx_sh[0];
                sda_oe <= 1'b1;
                state  <= ST_CACK;
              end else begin
                state  <= ST_IDLE;
              end
            end else if (state == ST_ADDR) begin
              ptr    <= {blk_q, rx_sh[WORD_W-1:0]};
              sda_oe <= 1'b1;
              state  <= ST_AACK;
            end else begin
              ptr    <= ptr + AW'(1);
              sda_oe <= 1'b1;
              state  <= ST_WACK;
            end
          end
        end
        ST_CACK: begin
          if (scl_fall) begin
            if (rd_dir) begin
              tx_sh   <= {mem_rd[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~mem_rd[BYTE_W-1];
              ptr     <= ptr + AW'(1);
              bit_cnt <= '0;
              state   <= ST_RDAT;
            end else begin
              sda_oe  <= 1'b0;
              state   <= ST_ADDR;
            end
          end
        end
        ST_AACK, ST_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt == FULL) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end else begin
              sda_oe <= ~tx_sh[BYTE_W-1];
              tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack) begin
              tx_sh   <= {mem_rd[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~mem_rd[BYTE_W-1];
              ptr     <= ptr + AW'(1);
              bit_cnt <= '0;
              state   <= ST_RDAT;
            end else begin
              sda_oe  <= 1'b0;
              state   <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R6: the pad is only newly pulled low in the clock-low phase
  a_r6_drive_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));

  // R1: an idle slave never drives the bus
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R9: START leaves a fresh control-byte phase
  a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state == ST_CTRL) && (bit_cnt == '0) && !sda_oe);

  // R9: STOP idles and releases
  a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE) && !sda_oe);

  // R3: each stored byte moves the pointer by one
  a_r3_store_advances: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr == $past(ptr) + AW'(1)));

endmodule

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;

  localparam int H   = 8;
  localparam int MSZ = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_mem_slave dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_in (scl_m),
    .sda_in (sda_line),
    .sda_oe (sda_oe)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit oe_seen = 0;
  logic [7:0] model [MSZ];
  bit valid [MSZ];
  int mptr = 0;

  always @(negedge clk) if (sda_oe) oe_seen = 1;

  function automatic int wrap_a(int a);
    return a & (MSZ - 1);
  endfunction

  function automatic logic [7:0] ctrl_byte(logic [3:0] dev, int blk, bit rd);
    return {dev, blk[2:0], rd};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic bus_start();
    sda_m = 1; tick(H/2);
    scl_m = 1; tick(H);
    sda_m = 0; tick(H);
    scl_m = 0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(H/2);
    scl_m = 1; tick(H);
    sda_m = 1; tick(H);
  endtask

  task automatic wbit(bit b);
    sda_m = b; tick(H-2);
    scl_m = 1; tick(H);
    scl_m = 0; tick(2);
  endtask

  task automatic rbit(output bit b);
    sda_m = 1; tick(H-2);
    scl_m = 1; tick(H/2);
    b = sda_line; tick(H/2);
    scl_m = 0; tick(2);
  endtask

  task automatic wbyte(logic [7:0] v, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(x);
    ack = !x;
  endtask

  task automatic rbyte(bit give_ack, output logic [7:0] v);
    bit x;
    for (int i = 7; i >= 0; i--) begin
      rbit(x);
      v[i] = x;
    end
    wbit(!give_ack);
  endtask

  task automatic do_write(int a, int n, logic [7:0] first, bit rnd);
    bit ack;
    logic [7:0] d;
    bus_start();
    wbyte(ctrl_byte(4'hA, a >> 8, 0), ack); chk("R1 ctrl ack", ack, 1);
    wbyte(a[7:0], ack);                     chk("R2 addr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      d = rnd ? 8'($urandom) : first + 8'(k * 17);
      wbyte(d, ack); chk("R3 data ack", ack, 1);
      model[wrap_a(a + k)] = d;
      valid[wrap_a(a + k)] = 1;
    end
    bus_stop();
    mptr = wrap_a(a + n);
  endtask

  task automatic read_body(int n, string req);
    logic [7:0] v;
    for (int k = 0; k < n; k++) begin
      rbyte(k < n - 1, v);
      if (valid[mptr]) chk(req, v, model[mptr]);
      mptr = wrap_a(mptr + 1);
    end
  endtask

  task automatic do_rand_read(int a, int n, string req);
    bit ack;
    bus_start();
    wbyte(ctrl_byte(4'hA, a >> 8, 0), ack); chk("R2 ctrl ack", ack, 1);
    wbyte(a[7:0], ack);                     chk("R2 addr ack", ack, 1);
    bus_start();
    wbyte(ctrl_byte(4'hA, $urandom_range(0, 7), 1), ack); chk("R5 rd ctrl ack", ack, 1);
    mptr = a;
    read_body(n, req);
    bus_stop();
  endtask

  task automatic do_cur_read(int n, string req);
    bit ack;
    bus_start();
    wbyte(ctrl_byte(4'hA, $urandom_range(0, 7), 1), ack); chk("R5 rd ctrl ack", ack, 1);
    read_body(n, req);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    bit ack, x;
    logic [7:0] v;
    process::self().srandom(32'h1D5);
    tick(4);
    rst_n = 1; tick(4);
    chk("R10 oe after reset", sda_oe, 0);

    // seed low memory, then reset: pointer must restart at 0
    do_write(0, 6, 8'h5A, 0);
    rst_n = 0; tick(3); rst_n = 1; tick(4);
    chk("R10 oe after second reset", sda_oe, 0);
    mptr = 0;
    do_cur_read(1, "R10 read at pointer 0");

    // foreign device field: no ack, later clocks ignored, pointer kept
    bus_start();
    wbyte(ctrl_byte(4'h5, 0, 1), ack); chk("R1 foreign nack", ack, 0);
    oe_seen = 0;
    wbyte(ctrl_byte(4'hA, 0, 1), ack);
    chk("R1 ignored until START", oe_seen, 0);
    bus_stop();
    do_cur_read(1, "R1 pointer kept after foreign byte");

    // partial write byte cut by repeated START
    do_write(12'h240, 1, 8'hC3, 0);
    bus_start();
    wbyte(ctrl_byte(4'hA, 2, 0), ack);
    wbyte(8'h40, ack);
    for (int i = 0; i < 4; i++) wbit(1'b0);
    bus_start();
    wbyte(ctrl_byte(4'hA, 5, 1), ack); chk("R4 rd ctrl ack", ack, 1);
    mptr = 12'h240;
    read_body(1, "R4 old byte kept");
    bus_stop();

    // wrap at the top of memory
    do_write(MSZ - 1, 3, 8'h70, 0);
    do_rand_read(MSZ - 1, 3, "R8 wrap read");
    do_cur_read(1, "R8 continue after wrap");

    // NACK then further clocks: nothing driven
    do_cur_read(1, "R7 single byte");
    bus_start();
    wbyte(ctrl_byte(4'hA, 0, 1), ack);
    rbyte(0, v);
    chk("R6 msb-first byte", v, model[mptr]);
    mptr = wrap_a(mptr + 1);
    oe_seen = 0;
    for (int i = 0; i < 9; i++) rbit(x);
    chk("R7 released after nack", oe_seen, 0);
    bus_stop();

    // START in mid control byte, STOP in mid address byte
    do_write(100, 4, 8'h21, 0);
    bus_start();
    wbit(1); wbit(0); wbit(1);
    bus_start();
    wbyte(ctrl_byte(4'hA, 0, 1), ack); chk("R9 ctrl after mid-byte START", ack, 1);
    read_body(2, "R9 read after restart");
    bus_stop();
    bus_start();
    wbyte(ctrl_byte(4'hA, 3, 0), ack);
    for (int i = 0; i < 4; i++) wbit(1'b1);
    bus_stop();
    do_cur_read(1, "R9 pointer kept after STOP");

    // constrained random mix
    for (int it = 0; it < 45; it++) begin
      int op, a;
      op = $urandom_range(0, 2);
      a  = ($urandom_range(0, 7) << 8) | $urandom_range(0, 15);
      if (op == 0) do_write(a, $urandom_range(1, 4), 8'h00, 1);
      else if (op == 1) do_rand_read(a, $urandom_range(1, 4), "R2 R7 random read");
      else do_cur_read($urandom_range(1, 3), "R5 current read");
    end

    finish_run();
  end

endmodule